// File: doc/BRIEF.md
# Serial Converter Control-Word Receiver

This block is the device-side front end of a four-wire serial interface for a multi-channel data converter. The host selects the device by pulling chip select low. While chip select is low, the block samples the data-in line on each rising edge of the serial clock. Zeros clocked in before the first one carry no meaning. The first one is taken as the head of an 8-bit control word. The block collects the seven bits that follow. It then splits the word into a channel number, a polarity flag, an input-mode flag and a two-bit power/clock mode. It presents these values together with a one-cycle strobe, and at the same time issues a one-cycle conversion-request pulse to the converter core.

All three serial pins are raw, unsynchronised inputs. They are brought into the system clock domain through a two-flop synchroniser. Serial clock rising edges are detected in that domain, so the system clock must run at least four times faster than the serial clock.

A framing state machine moves through the states IDLE (deselected), HUNT (waiting for the leading one), SHIFT (collecting the body) and CONV (conversion window). The transitions are:
- IDLE to HUNT when chip select is low.
- HUNT to SHIFT on a sampled one.
- SHIFT to CONV on the eighth bit.
- CONV to HUNT after the window's last serial clock.
- Any state to IDLE when chip select is high.

A power state machine with the states DOWN and UP wakes on every chip-select falling edge. It drops back to DOWN at the end of a conversion window whose mode is one of the two power-down codes.

Top module: `adc_ctrl_rx`

## Requirements
- R1: Data-in is taken only on a serial clock rising edge while chip select is low; serial clock edges seen while chip select is high never produce a word, a strobe or a change of any decoded output.
- R2: After chip select falls, any number of leading zero bits are skipped; the first one bit sampled becomes bit 7 of the control word, and the next seven sampled bits fill bits 6 down to 0, most significant first.
- R3: Control-word fields: bits [6:4] drive `chan_sel`, bit 3 drives `unipolar` (1 = unipolar, 0 = bipolar), bit 2 drives `single_ended` (1 = single-ended against common, 0 = differential), bits [1:0] drive `pwr_mode`.
- R4: `pwr_mode` codes: 2'b00 full power-down, 2'b01 fast power-down, 2'b10 internal clock, 2'b11 external clock; all four pass through unaltered.
- R5: When a word completes, `word_valid` and `conv_req` are each high for exactly one system clock; the decoded outputs change only in a cycle where `word_valid` is high.
- R6: If chip select rises before all eight bits of a word are received, the partial word is dropped: no strobe is raised, the outputs keep their values, and the next word is framed from scratch after the next chip-select fall.
- R7: After a word completes, the next CONV_CLKS (default 15) serial clock rising edges are ignored; the search for a new leading one begins with the edge after them.
- R8: `powered_up` is 0 after reset and becomes 1 in the cycle after a chip-select falling edge is detected.
- R9: When the conversion window ends and the latched `pwr_mode` is 2'b00 or 2'b01, `powered_up` returns to 0; with 2'b10 or 2'b11 it stays 1.
- R10: Chip select rising during the conversion window abandons that window without changing `powered_up`; the next chip-select fall starts a fresh search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Raw chip select, active low |
| sclk_in | input | 1 | Raw serial clock, data taken on its rising edge |
| din_in | input | 1 | Raw serial data in |
| chan_sel | output | 3 | Decoded channel number |
| unipolar | output | 1 | 1 = unipolar, 0 = bipolar conversion |
| single_ended | output | 1 | 1 = single-ended, 0 = differential input |
| pwr_mode | output | 2 | Decoded power/clock mode |
| word_valid | output | 1 | One-cycle strobe marking fresh decoded values |
| conv_req | output | 1 | One-cycle conversion-request pulse |
| powered_up | output | 1 | Power state, 1 = awake |

## Verification
The assertions check several properties on every cycle:
- The strobe lasts exactly one cycle.
- The decoded fields hold steady between strobes.
- A strobe is never issued without chip select having been low.
- A chip-select fall always wakes the block.
- The power state only drops right after a conversion window closes.

The directed scenarios are what show the rest:
- the leading-zero skip and the field positions;
- the pass-through of every mode code;
- dropping a partial word;
- the exact length of the ignored window, down to the last edge;
- power-down or stay-awake depending on mode;
- abandoning a window when chip select rises early.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_HUNT  = 2'd1,
        FR_SHIFT = 2'd2,
        FR_CONV  = 2'd3
    } frame_state_t;

    typedef enum logic {
        PW_DOWN = 1'b0,
        PW_UP   = 1'b1
    } pwr_state_t;

    typedef enum logic [1:0] {
        PM_FULL_PD = 2'b00,
        PM_FAST_PD = 2'b01,
        PM_INT_CLK = 2'b10,
        PM_EXT_CLK = 2'b11
    } pwr_mode_t;

    // Body of the control word, the leading one already stripped
    typedef struct packed {
        logic [2:0] chan;
        logic       unipolar;
        logic       single_ended;
        pwr_mode_t  mode;
    } ctrl_body_t;

    localparam int BODY_BITS = $bits(ctrl_body_t);

    function automatic logic mode_sleeps(input pwr_mode_t m);
        return (m == PM_FULL_PD) || (m == PM_FAST_PD);
    endfunction

endpackage

// File: rtl/adc_rx_sync.sv
module adc_rx_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_rx_framer.sv
module adc_rx_framer
    import adc_rx_pkg::*;
#(
    parameter int NBITS     = BODY_BITS,
    parameter int CONV_CLKS = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_low,
    input  logic             sclk_rise,
    input  logic             din,
    output logic [NBITS-1:0] body,
    output logic             word_done,
    output logic             conv_end
);
    localparam int BCW = $clog2(NBITS + 1);
    localparam int CCW = $clog2(CONV_CLKS + 1);
    localparam logic [BCW-1:0] BIT_LAST  = BCW'(NBITS - 1);
    localparam logic [CCW-1:0] CONV_LAST = CCW'(CONV_CLKS - 1);

    frame_state_t    state, nstate;
    logic [BCW-1:0]  bit_cnt;
    logic [CCW-1:0]  conv_cnt;
    logic            take;

    assign take = cs_low && sclk_rise;

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            FR_IDLE:  if (cs_low) nstate = FR_HUNT;
            FR_HUNT:  if (!cs_low) nstate = FR_IDLE;
                      else if (take && din) nstate = FR_SHIFT;
            FR_SHIFT: if (!cs_low) nstate = FR_IDLE;
                      else if (take && bit_cnt == BIT_LAST) nstate = FR_CONV;
            FR_CONV:  if (!cs_low) nstate = FR_IDLE;
                      else if (take && conv_cnt == CONV_LAST) nstate = FR_HUNT;
            default:  nstate = FR_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= nstate;
    end

    // Datapath and output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body      <= '0;
            bit_cnt   <= '0;
            conv_cnt  <= '0;
            word_done <= 1'b0;
            conv_end  <= 1'b0;
        end else begin
            word_done <= 1'b0;
            conv_end  <= 1'b0;
            unique case (state)
                FR_IDLE, FR_HUNT: begin
                    bit_cnt  <= '0;
                    conv_cnt <= '0;
                end
                FR_SHIFT: begin
                    if (take) begin
                        body    <= {body[NBITS-2:0], din};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BIT_LAST) word_done <= 1'b1;
                    end
                    conv_cnt <= '0;
                end
                FR_CONV: begin
                    if (take) begin
                        conv_cnt <= conv_cnt + 1'b1;
                        if (conv_cnt == CONV_LAST) conv_end <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adc_rx_power.sv
module adc_rx_power
    import adc_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_fall,
    input  logic      conv_end,
    input  pwr_mode_t mode,
    output logic      powered_up
);
    pwr_state_t state, nstate;

    always_comb begin
        nstate = state;
        unique case (state)
            PW_DOWN: if (cs_fall) nstate = PW_UP;
            PW_UP:   if (conv_end && mode_sleeps(mode)) nstate = PW_DOWN;
            default: nstate = PW_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PW_DOWN;
        else        state <= nstate;
    end

    always_comb powered_up = (state == PW_UP);
endmodule

// File: rtl/adc_ctrl_rx.sv
module adc_ctrl_rx
    import adc_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CONV_CLKS   = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_in,
    input  logic       sclk_in,
    input  logic       din_in,
    output logic [2:0] chan_sel,
    output logic       unipolar,
    output logic       single_ended,
    output logic [1:0] pwr_mode,
    output logic       word_valid,
    output logic       conv_req,
    output logic       powered_up
);
    logic [2:0]       pins_s;
    logic             cs_n_s, sclk_s, din_s;
    logic             cs_n_d, sclk_d;
    logic             cs_low, cs_fall, sclk_rise;
    logic [BODY_BITS-1:0] body;
    logic             word_done, conv_end;
    ctrl_body_t       cw;
    pwr_mode_t        mode_q;

    adc_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n_in, sclk_in, din_in}),
        .q(pins_s)
    );
    assign {cs_n_s, sclk_s, din_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_d <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_n_d <= cs_n_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_low    = !cs_n_s;
    assign cs_fall   = cs_n_d && !cs_n_s;
    assign sclk_rise = sclk_s && !sclk_d;

    adc_rx_framer #(.NBITS(BODY_BITS), .CONV_CLKS(CONV_CLKS)) u_framer (
        .clk(clk), .rst_n(rst_n),
        .cs_low(cs_low), .sclk_rise(sclk_rise), .din(din_s),
        .body(body), .word_done(word_done), .conv_end(conv_end)
    );

    assign cw = ctrl_body_t'(body);

    // Decode registers, loaded once per complete word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_sel     <= '0;
            unipolar     <= 1'b0;
            single_ended <= 1'b0;
            mode_q       <= PM_FULL_PD;
            word_valid   <= 1'b0;
            conv_req     <= 1'b0;
        end else begin
            word_valid <= word_done;
            conv_req   <= word_done;
            if (word_done) begin
                chan_sel     <= cw.chan;
                unipolar     <= cw.unipolar;
                single_ended <= cw.single_ended;
                mode_q       <= cw.mode;
            end
        end
    end

    assign pwr_mode = mode_q;

    adc_rx_power u_power (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .conv_end(conv_end),
        .mode(mode_q), .powered_up(powered_up)
    );
endmodule

// File: rtl/adc_ctrl_rx_chk.sv
module adc_ctrl_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_s,
    input logic       conv_end,
    input logic [2:0] chan_sel,
    input logic       unipolar,
    input logic       single_ended,
    input logic [1:0] pwr_mode,
    input logic       word_valid,
    input logic       conv_req,
    input logic       powered_up
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R5

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req); // R5

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable({chan_sel, unipolar, single_ended, pwr_mode})); // R5

    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(!cs_n_s)); // R1

    AST_WAKE_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_s) |=> powered_up); // R8

    AST_SLEEP_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered_up) |-> $past(conv_end)); // R9
endmodule

bind adc_ctrl_rx adc_ctrl_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .conv_end(conv_end),
    .chan_sel(chan_sel), .unipolar(unipolar), .single_ended(single_ended),
    .pwr_mode(pwr_mode), .word_valid(word_valid), .conv_req(conv_req),
    .powered_up(powered_up)
);

// File: tb/adc_ctrl_rx_test.sv
module adc_ctrl_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic [2:0] chan_sel;
    logic unipolar, single_ended, word_valid, conv_req, powered_up;
    logic [1:0] pwr_mode;

    int n_chk = 0, n_bad = 0;
    int n_valid = 0, n_req = 0;

    always #10 clk = ~clk;

    adc_ctrl_rx uut (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk), .din_in(din),
        .chan_sel(chan_sel), .unipolar(unipolar), .single_ended(single_ended),
        .pwr_mode(pwr_mode), .word_valid(word_valid), .conv_req(conv_req),
        .powered_up(powered_up)
    );

    always @(negedge clk) begin
        if (word_valid) n_valid++;
        if (conv_req)   n_req++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk); din = b; sclk = 1'b0;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
    endtask

    task automatic byte_out(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) bit_out(w[i]);
        wait_clk(4);
    endtask

    task automatic select(input logic lvl);
        @(negedge clk); cs_n = lvl;
        wait_clk(6);
    endtask

    task automatic fields(input string req, input int ch, input int u, input int s, input int m);
        chk({req, " chan_sel"}, chan_sel, ch);
        chk({req, " unipolar"}, unipolar, u);
        chk({req, " single_ended"}, single_ended, s);
        chk({req, " pwr_mode"}, pwr_mode, m);
    endtask

    task automatic t_reset();
        fields("R8 reset", 0, 0, 0, 0);
        chk("R8 reset powered_up", powered_up, 0);
        chk("R5 reset strobe", word_valid, 0);
    endtask

    task automatic t_basic();
        select(1'b0);
        chk("R8 wake on select", powered_up, 1);
        bit_out(0); bit_out(0); bit_out(0);
        byte_out(8'b1_101_1_0_11);
        fields("R2 R3 R4 first word", 5, 1, 0, 3);
        chk("R5 one strobe", n_valid, 1);
        chk("R5 one request", n_req, 1);
        // R7: window of 15 edges, ones inside must be ignored
        for (int i = 0; i < 15; i++) bit_out(1'b1);
        wait_clk(4);
        chk("R7 no strobe in window", n_valid, 1);
        fields("R7 fields held", 5, 1, 0, 3);
        chk("R9 ext clock stays awake", powered_up, 1);
        byte_out(8'b1_010_0_1_10);
        fields("R3 R4 second word", 2, 0, 1, 2);
        chk("R5 second strobe", n_valid, 2);
        for (int i = 0; i < 15; i++) bit_out(1'b0);
        wait_clk(4);
        chk("R9 int clock stays awake", powered_up, 1);
        select(1'b1);
    endtask

    task automatic t_deselected();
        for (int i = 0; i < 10; i++) bit_out(1'b1);
        wait_clk(4);
        chk("R1 no strobe when deselected", n_valid, 2);
        fields("R1 fields held", 2, 0, 1, 2);
    endtask

    task automatic t_abort();
        select(1'b0);
        bit_out(1); bit_out(1); bit_out(1); bit_out(1);
        select(1'b1);
        chk("R6 no strobe on partial", n_valid, 2);
        fields("R6 fields held", 2, 0, 1, 2);
        select(1'b0);
        byte_out(8'b1_001_1_1_01);
        fields("R6 fresh word", 1, 1, 1, 1);
        chk("R6 single strobe", n_valid, 3);
        for (int i = 0; i < 15; i++) bit_out(1'b0);
        wait_clk(4);
        chk("R9 fast power-down sleeps", powered_up, 0);
        select(1'b1);
    endtask

    task automatic t_full_pd();
        select(1'b0);
        chk("R8 wake again", powered_up, 1);
        byte_out(8'b1_111_0_0_00);
        fields("R3 R4 full power-down word", 7, 0, 0, 0);
        for (int i = 0; i < 14; i++) bit_out(1'b1);
        wait_clk(4);
        chk("R7 R9 awake before last edge", powered_up, 1);
        chk("R7 still ignored", n_valid, 4);
        bit_out(1'b0);
        wait_clk(4);
        chk("R9 full power-down sleeps", powered_up, 0);
        byte_out(8'b1_100_0_1_11);
        fields("R7 hunt after window", 4, 0, 1, 3);
        select(1'b1);
    endtask

    task automatic t_cs_in_window();
        select(1'b0);
        byte_out(8'b1_011_1_0_00);
        for (int i = 0; i < 5; i++) bit_out(1'b0);
        select(1'b1);
        wait_clk(10);
        chk("R10 stays awake after abandon", powered_up, 1);
        select(1'b0);
        byte_out(8'b1_110_1_1_01);
        fields("R10 fresh hunt", 6, 1, 1, 1);
        chk("R10 strobe count", n_valid, 7);
        select(1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_basic();
        t_deselected();
        t_abort();
        t_full_pd();
        t_cs_in_window();
        chk("R5 request matches strobe", n_req, n_valid);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule